// File: doc/BRIEF.md
# Wavefront Issue Scheduler

This block decides, once per clock, which resident wavefront of a compute unit sends its next instruction to a SIMD vector unit. The compute unit has four SIMD units and the scheduler visits them in fixed rotation, one per cycle. Each SIMD unit owns ten wavefront slots. A wavefront stays in the slot it was given at allocation, so it always issues on the same SIMD unit. Each slot holds a valid bit and a waiting-on-memory bit. An external ready vector says which slots have an instruction pending.

On its turn, a SIMD unit issues from the first eligible slot after the slot it last issued from. A slot is eligible when it is valid, not waiting and ready. A 64-thread wavefront on a 16-lane unit holds that unit for four cycles. A wavefront that waits on memory is passed over, and another wavefront of the same unit is used in its place. The surrounding logic sends in four kinds of event: allocate, retire, mark-waiting and memory-return. It receives one issue grant per cycle, made up of a pulse and the SIMD and slot indices.

Top module: `wave_issue_sched`

## Requirements
- R1: While reset is asserted, issue_valid is 0 and issue_simd is 0 even if every ready bit is set, and no slot is valid.
- R2: issue_simd advances by one every cycle after reset release and wraps from 3 to 0. Only the SIMD named by issue_simd can be granted, and at most one grant is made per cycle.
- R3: A grant goes only to a slot that is valid, not waiting and ready. The ready bit for slot k of SIMD s is inst_ready[s*10+k].
- R4: The visited SIMD grants the first eligible slot after the slot it last issued from, searching in ascending order and wrapping from 9 to 0. After reset the search starts at slot 0.
- R5: After a grant, a SIMD gets no further grant for the following three cycles. With the defaults, a SIMD that stays eligible is granted exactly every four cycles. A visited SIMD with no eligible slot produces issue_valid 0.
- R6: An allocate request to a SIMD with a free slot answers in the same cycle with alloc_ack 1 and alloc_slot equal to the lowest free slot index. That slot is valid and not waiting from the next cycle. If all ten slots are valid, the request gets alloc_full 1 and alloc_ack 0, and no state changes.
- R7: A retired slot stays valid in the cycle of the retire request and can still be granted in that cycle. It is invalid from the next cycle and can then be allocated again.
- R8: A mark-waiting request makes its slot ineligible from the next cycle. A memory return clears the waiting bit, so the slot is eligible from the next cycle. If both requests target the same slot in the same cycle, the slot stays waiting.
- R9: A wavefront allocated to SIMD s is only ever granted with issue_simd equal to s.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| alloc_req | input | 1 | Request a new wavefront slot |
| alloc_simd | input | 2 | Target SIMD of the allocation |
| alloc_ack | output | 1 | Allocation accepted this cycle |
| alloc_full | output | 1 | Allocation refused because the target has no free slot |
| alloc_slot | output | 4 | Slot index given to the allocation |
| retire_req | input | 1 | Free a slot |
| retire_simd | input | 2 | SIMD of the slot being retired |
| retire_slot | input | 4 | Slot being retired |
| mem_wait_req | input | 1 | Mark a slot as waiting on memory |
| mem_wait_simd | input | 2 | SIMD of the slot to mark |
| mem_wait_slot | input | 4 | Slot to mark |
| mem_ret_req | input | 1 | Memory result returned; clear the waiting bit |
| mem_ret_simd | input | 2 | SIMD of the returning slot |
| mem_ret_slot | input | 4 | Returning slot |
| inst_ready | input | 40 | Pending-instruction bit for each slot, slot k of SIMD s at bit s*10+k |
| issue_valid | output | 1 | Grant pulse this cycle |
| issue_simd | output | 2 | SIMD visited this cycle |
| issue_slot | output | 4 | Slot granted when issue_valid is 1 |

## Verification
The case most likely to hide a bug is a retire that lands in the same cycle as a grant to the slot being retired. The bench provokes it by driving retire_req for the slot it expects to be granted, while that SIMD is being visited. It then requires the grant to appear unchanged in that cycle. On the next visit to that SIMD it requires the retired slot to be skipped, and it requires a later allocation to hand the same slot index back. A second collision pairs a mark-waiting request with a memory return on the same slot. This is judged by the slot still being skipped on the next visit, and by the slot becoming eligible once a memory return arrives alone.

// File: rtl/wis_pkg.sv
package wis_pkg;
  localparam int unsigned WIS_SIMDS = 4;
  localparam int unsigned WIS_SLOTS = 10;
  localparam int unsigned WIS_BUSY  = 4;

  // width needed to hold values 0..n-1, at least one bit
  function automatic int unsigned idx_w(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/wis_rst_sync.sv
module wis_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q     <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      meta_q     <= 1'b1;
      rst_sync_n <= meta_q;
    end
  end
endmodule

// File: rtl/wis_rr_pick.sv
module wis_rr_pick #(
  parameter int unsigned N = 10,
  parameter int unsigned W = 4
) (
  input  logic [N-1:0] elig,
  input  logic [W-1:0] last,
  output logic         found,
  output logic [W-1:0] pick
);
  int idx;

  always_comb begin
    found = 1'b0;
    pick  = '0;
    idx   = 0;
    for (int off = 1; off <= int'(N); off++) begin
      idx = (int'(last) + off) % int'(N);
      if (!found && elig[idx]) begin
        found = 1'b1;
        pick  = W'(idx);
      end
    end
  end
endmodule

// File: rtl/wis_free_find.sv
module wis_free_find #(
  parameter int unsigned N = 10,
  parameter int unsigned W = 4
) (
  input  logic [N-1:0] valid,
  output logic         full,
  output logic [W-1:0] slot
);
  always_comb begin
    full = &valid;
    slot = '0;
    for (int k = int'(N) - 1; k >= 0; k--) begin
      if (!valid[k]) slot = W'(k);
    end
  end
endmodule

// File: rtl/wis_simd_ctrl.sv
module wis_simd_ctrl #(
  parameter int unsigned SLOTS    = 10,
  parameter int unsigned BUSY_CYC = 4,
  parameter int unsigned KW       = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel,
  input  logic             alloc_en,
  input  logic             retire_en,
  input  logic [KW-1:0]    retire_slot,
  input  logic             wset_en,
  input  logic [KW-1:0]    wset_slot,
  input  logic             wclr_en,
  input  logic [KW-1:0]    wclr_slot,
  input  logic [SLOTS-1:0] ready,
  output logic             full,
  output logic [KW-1:0]    free_slot,
  output logic             grant,
  output logic [KW-1:0]    grant_slot,
  output logic [SLOTS-1:0] valid_o,
  output logic [SLOTS-1:0] wait_o
);
  localparam int unsigned BW = $clog2(BUSY_CYC + 1);

  logic [SLOTS-1:0] valid_q, valid_d, wait_q, wait_d;
  logic [BW-1:0]    busy_q, busy_d;
  logic [KW-1:0]    last_q;
  logic             state_en, busy_en, found;
  logic [SLOTS-1:0] elig;
  logic [KW-1:0]    pick;

  wis_free_find #(.N(SLOTS), .W(KW)) u_free (
    .valid (valid_q),
    .full  (full),
    .slot  (free_slot)
  );

  assign elig = valid_q & ~wait_q & ready;

  wis_rr_pick #(.N(SLOTS), .W(KW)) u_pick (
    .elig  (elig),
    .last  (last_q),
    .found (found),
    .pick  (pick)
  );

  assign grant      = sel && (busy_q == '0) && found;
  assign grant_slot = pick;

  // slot state next value; later statements take priority
  always_comb begin
    valid_d = valid_q;
    wait_d  = wait_q;
    if (retire_en && int'(retire_slot) < int'(SLOTS)) begin
      valid_d[retire_slot] = 1'b0;
      wait_d[retire_slot]  = 1'b0;
    end
    if (alloc_en) begin
      valid_d[free_slot] = 1'b1;
      wait_d[free_slot]  = 1'b0;
    end
    if (wclr_en && int'(wclr_slot) < int'(SLOTS)) wait_d[wclr_slot] = 1'b0;
    if (wset_en && int'(wset_slot) < int'(SLOTS)) wait_d[wset_slot] = 1'b1;
  end

  assign state_en = retire_en | alloc_en | wclr_en | wset_en;

  always_comb begin
    busy_d = busy_q;
    if (busy_q != '0) busy_d = busy_q - 1'b1;
    if (grant)        busy_d = BW'(BUSY_CYC - 1);
  end

  assign busy_en = grant | (busy_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      wait_q  <= '0;
    end else if (state_en) begin
      valid_q <= valid_d;
      wait_q  <= wait_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       busy_q <= '0;
    else if (busy_en) busy_q <= busy_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     last_q <= KW'(SLOTS - 1);
    else if (grant) last_q <= pick;
  end

  assign valid_o = valid_q;
  assign wait_o  = wait_q;
endmodule

// File: rtl/wave_issue_sched.sv
module wave_issue_sched #(
  parameter int unsigned NUM_SIMD = wis_pkg::WIS_SIMDS,
  parameter int unsigned SLOTS    = wis_pkg::WIS_SLOTS,
  parameter int unsigned BUSY_CYC = wis_pkg::WIS_BUSY,
  parameter int unsigned SW       = wis_pkg::idx_w(NUM_SIMD),
  parameter int unsigned KW       = wis_pkg::idx_w(SLOTS)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      alloc_req,
  input  logic [SW-1:0]             alloc_simd,
  output logic                      alloc_ack,
  output logic                      alloc_full,
  output logic [KW-1:0]             alloc_slot,
  input  logic                      retire_req,
  input  logic [SW-1:0]             retire_simd,
  input  logic [KW-1:0]             retire_slot,
  input  logic                      mem_wait_req,
  input  logic [SW-1:0]             mem_wait_simd,
  input  logic [KW-1:0]             mem_wait_slot,
  input  logic                      mem_ret_req,
  input  logic [SW-1:0]             mem_ret_simd,
  input  logic [KW-1:0]             mem_ret_slot,
  input  logic [NUM_SIMD*SLOTS-1:0] inst_ready,
  output logic                      issue_valid,
  output logic [SW-1:0]             issue_simd,
  output logic [KW-1:0]             issue_slot
);
  localparam int unsigned TOTAL = NUM_SIMD * SLOTS;

  logic                rst_sync_n;
  logic [SW-1:0]       cur_q, cur_d;
  logic [NUM_SIMD-1:0] full_vec, grant_vec;
  logic [KW-1:0]       free_arr  [NUM_SIMD];
  logic [KW-1:0]       gslot_arr [NUM_SIMD];
  logic [TOTAL-1:0]    valid_flat, wait_flat;
  logic                tgt_full;

  wis_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  // rotation over the SIMD units, one per cycle
  assign cur_d = (cur_q == SW'(NUM_SIMD - 1)) ? '0 : cur_q + 1'b1;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) cur_q <= '0;
    else             cur_q <= cur_d;
  end

  assign tgt_full = full_vec[alloc_simd];

  generate
    for (genvar s = 0; s < int'(NUM_SIMD); s++) begin : g_simd
      wis_simd_ctrl #(.SLOTS(SLOTS), .BUSY_CYC(BUSY_CYC), .KW(KW)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_sync_n),
        .sel         (cur_q == SW'(s)),
        .alloc_en    (alloc_req && alloc_simd == SW'(s) && !full_vec[s]),
        .retire_en   (retire_req && retire_simd == SW'(s)),
        .retire_slot (retire_slot),
        .wset_en     (mem_wait_req && mem_wait_simd == SW'(s)),
        .wset_slot   (mem_wait_slot),
        .wclr_en     (mem_ret_req && mem_ret_simd == SW'(s)),
        .wclr_slot   (mem_ret_slot),
        .ready       (inst_ready[s*SLOTS +: SLOTS]),
        .full        (full_vec[s]),
        .free_slot   (free_arr[s]),
        .grant       (grant_vec[s]),
        .grant_slot  (gslot_arr[s]),
        .valid_o     (valid_flat[s*SLOTS +: SLOTS]),
        .wait_o      (wait_flat[s*SLOTS +: SLOTS])
      );
    end
  endgenerate

  assign alloc_ack   = alloc_req & ~tgt_full;
  assign alloc_full  = alloc_req &  tgt_full;
  assign alloc_slot  = free_arr[alloc_simd];
  assign issue_valid = |grant_vec;
  assign issue_simd  = cur_q;
  assign issue_slot  = gslot_arr[cur_q];
endmodule

// File: rtl/wave_issue_sched_chk.sv
module wave_issue_sched_chk #(
  parameter int unsigned NUM_SIMD = 4,
  parameter int unsigned SLOTS    = 10,
  parameter int unsigned BUSY_CYC = 4,
  parameter int unsigned SW       = 2,
  parameter int unsigned KW       = 4
) (
  input logic                      clk,
  input logic                      rst_sync_n,
  input logic                      issue_valid,
  input logic [SW-1:0]             issue_simd,
  input logic [KW-1:0]             issue_slot,
  input logic                      alloc_ack,
  input logic [SW-1:0]             alloc_simd,
  input logic [KW-1:0]             alloc_slot,
  input logic                      retire_req,
  input logic [SW-1:0]             retire_simd,
  input logic [KW-1:0]             retire_slot,
  input logic [NUM_SIMD*SLOTS-1:0] valid_flat,
  input logic [NUM_SIMD*SLOTS-1:0] wait_flat,
  input logic [NUM_SIMD*SLOTS-1:0] inst_ready,
  input logic [NUM_SIMD-1:0]       grant_vec
);
  localparam int unsigned TOTAL = NUM_SIMD * SLOTS;
  localparam int unsigned BW    = $clog2(BUSY_CYC + 1);

  int          iss_idx, a_idx_d, r_idx_d;
  int          a_idx_q, r_idx_q;
  logic        a_pend_q, r_pend_q;
  logic [BW-1:0] since_q [NUM_SIMD];

  always_comb begin
    iss_idx = int'(issue_simd) * int'(SLOTS) + int'(issue_slot);
    if (iss_idx >= int'(TOTAL)) iss_idx = 0;
    a_idx_d = int'(alloc_simd) * int'(SLOTS) + int'(alloc_slot);
    if (a_idx_d >= int'(TOTAL)) a_idx_d = 0;
    r_idx_d = int'(retire_simd) * int'(SLOTS) + int'(retire_slot);
    if (r_idx_d >= int'(TOTAL)) r_idx_d = 0;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      a_pend_q <= 1'b0;
      r_pend_q <= 1'b0;
      a_idx_q  <= 0;
      r_idx_q  <= 0;
    end else begin
      a_pend_q <= alloc_ack;
      r_pend_q <= retire_req && int'(retire_slot) < int'(SLOTS);
      a_idx_q  <= a_idx_d;
      r_idx_q  <= r_idx_d;
    end
  end

  generate
    for (genvar s = 0; s < int'(NUM_SIMD); s++) begin : g_gap
      always_ff @(posedge clk or negedge rst_sync_n) begin
        if (!rst_sync_n)
          since_q[s] <= BW'(BUSY_CYC);
        else if (issue_valid && issue_simd == SW'(s))
          since_q[s] <= BW'(1);
        else if (since_q[s] < BW'(BUSY_CYC))
          since_q[s] <= since_q[s] + 1'b1;
      end

      p_occupancy_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
        (issue_valid && issue_simd == SW'(s)) |-> (since_q[s] >= BW'(BUSY_CYC)))
        else $error("R5: SIMD %0d granted inside its busy window", s);
    end
  endgenerate

  p_rotation_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rst_sync_n && $past(rst_sync_n)) |->
      (int'(issue_simd) == (int'($past(issue_simd)) + 1) % int'(NUM_SIMD)))
    else $error("R2: visited SIMD did not advance by one");

  p_single_grant_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $onehot0(grant_vec))
    else $error("R2: more than one SIMD granted");

  p_eligible_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    issue_valid |-> (valid_flat[iss_idx] && !wait_flat[iss_idx] && inst_ready[iss_idx]))
    else $error("R3: grant to an ineligible slot");

  p_alloc_lands_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    a_pend_q |-> (valid_flat[a_idx_q] && !wait_flat[a_idx_q]))
    else $error("R6: allocated slot not valid next cycle");

  p_retire_frees_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (r_pend_q && !(a_pend_q && a_idx_q == r_idx_q)) |-> !valid_flat[r_idx_q])
    else $error("R7: retired slot still valid");
endmodule

bind wave_issue_sched wave_issue_sched_chk #(
  .NUM_SIMD (NUM_SIMD),
  .SLOTS    (SLOTS),
  .BUSY_CYC (BUSY_CYC),
  .SW       (SW),
  .KW       (KW)
) u_chk (
  .clk         (clk),
  .rst_sync_n  (rst_sync_n),
  .issue_valid (issue_valid),
  .issue_simd  (issue_simd),
  .issue_slot  (issue_slot),
  .alloc_ack   (alloc_ack),
  .alloc_simd  (alloc_simd),
  .alloc_slot  (alloc_slot),
  .retire_req  (retire_req),
  .retire_simd (retire_simd),
  .retire_slot (retire_slot),
  .valid_flat  (valid_flat),
  .wait_flat   (wait_flat),
  .inst_ready  (inst_ready),
  .grant_vec   (grant_vec)
);

// File: tb/wave_issue_sched_test.sv
`timescale 1ns/1ps
module wave_issue_sched_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        alloc_req;
  logic [1:0]  alloc_simd;
  logic        alloc_ack, alloc_full;
  logic [3:0]  alloc_slot;
  logic        retire_req;
  logic [1:0]  retire_simd;
  logic [3:0]  retire_slot;
  logic        mem_wait_req;
  logic [1:0]  mem_wait_simd;
  logic [3:0]  mem_wait_slot;
  logic        mem_ret_req;
  logic [1:0]  mem_ret_simd;
  logic [3:0]  mem_ret_slot;
  logic [39:0] inst_ready;
  logic        issue_valid;
  logic [1:0]  issue_simd;
  logic [3:0]  issue_slot;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  wave_issue_sched uut (
    .clk(clk), .rst_n(rst_n),
    .alloc_req(alloc_req), .alloc_simd(alloc_simd),
    .alloc_ack(alloc_ack), .alloc_full(alloc_full), .alloc_slot(alloc_slot),
    .retire_req(retire_req), .retire_simd(retire_simd), .retire_slot(retire_slot),
    .mem_wait_req(mem_wait_req), .mem_wait_simd(mem_wait_simd), .mem_wait_slot(mem_wait_slot),
    .mem_ret_req(mem_ret_req), .mem_ret_simd(mem_ret_simd), .mem_ret_slot(mem_ret_slot),
    .inst_ready(inst_ready),
    .issue_valid(issue_valid), .issue_simd(issue_simd), .issue_slot(issue_slot)
  );

  // {simd[1:0], expected ack, expected slot[3:0]}
  localparam logic [6:0] ALLOC_TAB [13] = '{
    {2'd1, 1'b1, 4'd0}, {2'd1, 1'b1, 4'd1}, {2'd1, 1'b1, 4'd2},
    {2'd1, 1'b1, 4'd3}, {2'd1, 1'b1, 4'd4}, {2'd1, 1'b1, 4'd5},
    {2'd1, 1'b1, 4'd6}, {2'd1, 1'b1, 4'd7}, {2'd1, 1'b1, 4'd8},
    {2'd1, 1'b1, 4'd9}, {2'd1, 1'b0, 4'd0}, {2'd2, 1'b1, 4'd0},
    {2'd2, 1'b1, 4'd1}
  };

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic next_cyc();
    @(negedge clk);
    alloc_req    = 1'b0;
    retire_req   = 1'b0;
    mem_wait_req = 1'b0;
    mem_ret_req  = 1'b0;
  endtask

  task automatic wait_visit(input int s, output int cycles);
    cycles = 0;
    do begin
      next_cyc();
      cycles++;
    end while (int'(issue_simd) != s);
    #1;
  endtask

  task automatic expect_issue(input string req, input int slot);
    chk(req, "issue_valid", int'(issue_valid), 1);
    chk(req, "issue_slot", int'(issue_slot), slot);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int n, prev;
    rst_n = 1'b0;
    alloc_req = 1'b0; alloc_simd = '0;
    retire_req = 1'b0; retire_simd = '0; retire_slot = '0;
    mem_wait_req = 1'b0; mem_wait_simd = '0; mem_wait_slot = '0;
    mem_ret_req = 1'b0; mem_ret_simd = '0; mem_ret_slot = '0;
    inst_ready = '1;

    // R1: reset state with every ready bit set
    repeat (3) @(negedge clk);
    #1;
    chk("R1", "issue_valid in reset", int'(issue_valid), 0);
    chk("R1", "issue_simd in reset", int'(issue_simd), 0);
    chk("R1", "alloc_full in reset", int'(alloc_full), 0);
    @(negedge clk);
    inst_ready = '0;
    rst_n = 1'b1;
    repeat (4) next_cyc();

    // R2: rotation
    prev = int'(issue_simd);
    for (int i = 0; i < 8; i++) begin
      next_cyc();
      chk("R2", "issue_simd step", int'(issue_simd), (prev + 1) % 4);
      prev = int'(issue_simd);
    end

    // R6: allocation table walk
    for (int i = 0; i < 13; i++) begin
      next_cyc();
      alloc_req  = 1'b1;
      alloc_simd = ALLOC_TAB[i][6:5];
      #1;
      chk("R6", "alloc_ack", int'(alloc_ack), int'(ALLOC_TAB[i][4]));
      chk("R6", "alloc_full", int'(alloc_full), int'(!ALLOC_TAB[i][4]));
      if (ALLOC_TAB[i][4]) chk("R6", "alloc_slot", int'(alloc_slot), int'(ALLOC_TAB[i][3:0]));
    end
    next_cyc();

    // R3: SIMD 2 slots valid but not ready -> no grant
    wait_visit(2, n);
    chk("R3", "no grant without ready", int'(issue_valid), 0);

    // R4/R5: round robin on SIMD 1 with every slot ready
    inst_ready[10 +: 10] = '1;
    for (int v = 0; v < 4; v++) begin
      wait_visit(1, n);
      expect_issue("R4", v);
      if (v > 0) chk("R5", "cycles between grants", n, 4);
    end
    wait_visit(3, n);
    chk("R5", "empty SIMD no grant", int'(issue_valid), 0);

    // R9: SIMD 2 slot 0 reported only on SIMD 2
    inst_ready[20] = 1'b1;
    wait_visit(2, n);
    expect_issue("R9", 0);
    chk("R9", "issue_simd", int'(issue_simd), 2);
    inst_ready[20] = 1'b0;

    // R8: waiting skip, set-wins collision, return
    inst_ready[10 +: 10] = 10'b0010100000; // slots 5 and 7
    wait_visit(0, n);
    mem_wait_req = 1'b1; mem_wait_simd = 2'd1; mem_wait_slot = 4'd5;
    wait_visit(1, n);
    expect_issue("R8", 7);
    wait_visit(1, n);
    expect_issue("R8", 7);
    wait_visit(0, n);
    mem_wait_req = 1'b1; mem_wait_simd = 2'd1; mem_wait_slot = 4'd5;
    mem_ret_req  = 1'b1; mem_ret_simd  = 2'd1; mem_ret_slot  = 4'd5;
    wait_visit(1, n);
    expect_issue("R8", 7);
    wait_visit(0, n);
    mem_ret_req = 1'b1; mem_ret_simd = 2'd1; mem_ret_slot = 4'd5;
    wait_visit(1, n);
    expect_issue("R8", 5);

    // R7: retire the slot being granted in the same cycle
    wait_visit(1, n);
    retire_req = 1'b1; retire_simd = 2'd1; retire_slot = 4'd7;
    #1;
    expect_issue("R7", 7);
    wait_visit(1, n);
    expect_issue("R7", 5);
    next_cyc();
    alloc_req = 1'b1; alloc_simd = 2'd1;
    #1;
    chk("R7", "reallocated slot", int'(alloc_slot), 7);
    chk("R6", "alloc_ack after retire", int'(alloc_ack), 1);
    next_cyc();
    alloc_req = 1'b1; alloc_simd = 2'd1;
    #1;
    chk("R6", "alloc_full again", int'(alloc_full), 1);
    next_cyc();

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule